// File: doc/BRIEF.md
# Triple Colour Lookup Table

The block maps each incoming pixel through three 256-by-8 tables, one for each of red, green and blue. It is used for gamma correction of true-colour pixels or for palette expansion of indexed pixels. In normal mode each channel's byte addresses its own table. In indexed mode the byte on the red lane is the index, and it addresses all three tables in the same cycle. The looked-up bytes are registered and appear one clock after the pixel.

The tables can be written in two ways. The first is a register write port, which takes a table select, an address and a data byte. The second is an in-band load taken from the pixel stream during a window just before the first active line. The window opens at the start of line `FIRST_ACTIVE-2` and closes halfway through line `FIRST_ACTIVE-1`. In that window the red lane carries 768 bytes, interleaved entry by entry as red, green, blue. Video timing comes from outside the block as a line number and a horizontal position.

Top module: `clut_triple`

## Requirements
- R1: While `rst` is high at a rising edge, all three outputs are 0 after that edge.
- R2: With `idx_mode`=0, `lut_r`, `lut_g` and `lut_b` equal the contents of the red, green and blue tables at the addresses `pix_r`, `pix_g` and `pix_b` sampled one clock earlier.
- R3: With `idx_mode`=1, all three tables are addressed by `pix_r`, and `pix_g` and `pix_b` have no effect on the outputs.
- R4: A register write with `reg_we`=1 writes `reg_data` at `reg_addr` into the table chosen by `reg_sel`: 0 selects red, 1 selects green, 2 selects blue. `reg_sel`=3 writes no table.
- R5: With `inband_en`=1, a byte on `pix_r` with `pix_valid`=1 is written in-band only in the load window. The window is every `hpos` of line `FIRST_ACTIVE-2`, plus `hpos` < `HALF_POS` on line `FIRST_ACTIVE-1`. Bytes outside the window are ignored.
- R6: In-band byte number k (counting from 0) is written to entry k/3. It goes to the red table when k mod 3 = 0, green when k mod 3 = 1 and blue when k mod 3 = 2.
- R7: The in-band byte counter restarts at 0 at `hpos`=0 of line `FIRST_ACTIVE-2`, including after a partial load. After 768 bytes it stops, and further bytes in the window are ignored.
- R8: When an in-band byte and a register write target the same table in the same cycle, the in-band byte is written and the register write is dropped. A register write to a different table in that cycle takes effect.
- R9: A lookup of an address that is written in the same cycle returns the previous contents. The new value is returned from the next cycle on.
- R10: With `inband_en`=0, pixel bytes in the window write no table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_mode | input | 1 | 1: the red lane indexes all three tables |
| pix_valid | input | 1 | The red-lane byte is a valid in-band load byte |
| pix_r | input | 8 | Red byte, or index, or in-band load byte |
| pix_g | input | 8 | Green byte |
| pix_b | input | 8 | Blue byte |
| line_cnt | input | LINE_W | Current line number |
| hpos | input | HPOS_W | Horizontal position in the line |
| inband_en | input | 1 | Enables in-band table loading |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Target table: 0 red, 1 green, 2 blue, 3 none |
| reg_addr | input | 8 | Register write address |
| reg_data | input | 8 | Register write data |
| lut_r | output | 8 | Red table output |
| lut_g | output | 8 | Green table output |
| lut_b | output | 8 | Blue table output |

## Verification
A register write and an in-band byte can reach the same table in one cycle. The bench provokes this during a partial in-band load. At a chosen byte it issues a register write to the green table, at an address the load never reaches, in the same cycle as an in-band green byte. The next cycle it writes green again while the in-band byte goes to blue. Sweeps through every entry afterwards must show the first register value absent and the second present. Separately, a register write and a lookup of the same address share one cycle, and the output must first show the old byte and then the new one.

// File: rtl/clut_pkg.sv
package clut_pkg;
    localparam int CW         = 8;
    localparam int NTAB       = 3;
    localparam int DEPTH      = 256;
    localparam int AW         = $clog2(DEPTH);
    localparam int LOAD_BYTES = NTAB * DEPTH;

    typedef logic [CW-1:0] byte_t;
    typedef logic [AW-1:0] addr_t;

    typedef enum logic [1:0] {
        TAB_R    = 2'd0,
        TAB_G    = 2'd1,
        TAB_B    = 2'd2,
        TAB_NONE = 2'd3
    } tab_e;

    typedef struct packed {
        logic  en;
        addr_t addr;
        byte_t data;
    } wr_t;

    function automatic tab_e next_tab(input tab_e t);
        case (t)
            TAB_R:   return TAB_G;
            TAB_G:   return TAB_B;
            default: return TAB_R;
        endcase
    endfunction
endpackage

// File: rtl/clut_bank.sv
module clut_bank
    import clut_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  wr_t   wr,
    input  addr_t rd_addr,
    output byte_t rd_data
);
    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr.en) mem[wr.addr] <= wr.data;
    end

    // read-first: nonblocking update leaves old word visible this edge
    always_ff @(posedge clk) begin
        if (rst) rd_data <= '0;
        else     rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/clut_window.sv
module clut_window
    import clut_pkg::*;
#(
    parameter int LINE_W       = 10,
    parameter int HPOS_W       = 11,
    parameter int FIRST_ACTIVE = 22,
    parameter int HALF_POS     = 429
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [LINE_W-1:0] line_cnt,
    input  logic [HPOS_W-1:0] hpos,
    input  logic              valid,
    input  byte_t             byte_in,
    output tab_e              wr_tab,
    output wr_t               wr
);
    localparam logic [LINE_W-1:0] PRE2 = LINE_W'(FIRST_ACTIVE - 2);
    localparam logic [LINE_W-1:0] PRE1 = LINE_W'(FIRST_ACTIVE - 1);
    localparam logic [HPOS_W-1:0] HALF = HPOS_W'(HALF_POS);
    localparam addr_t             LAST = AW'(DEPTH - 1);

    addr_t entry, eff_entry;
    tab_e  tab, eff_tab;
    logic  done, eff_done, start, in_win, take;

    always_comb begin
        start     = enable && (line_cnt == PRE2) && (hpos == '0);
        in_win    = enable && ((line_cnt == PRE2) ||
                               ((line_cnt == PRE1) && (hpos < HALF)));
        eff_entry = start ? '0    : entry;
        eff_tab   = start ? TAB_R : tab;
        eff_done  = start ? 1'b0  : done;
        take      = in_win && valid && !eff_done;
        wr_tab    = eff_tab;
        wr.en     = take;
        wr.addr   = eff_entry;
        wr.data   = byte_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            entry <= '0;
            tab   <= TAB_R;
            done  <= 1'b1;
        end else if (take) begin
            tab  <= next_tab(eff_tab);
            if (eff_tab == TAB_B) entry <= eff_entry + 1'b1;
            else                  entry <= eff_entry;
            done <= (eff_tab == TAB_B) && (eff_entry == LAST);
        end else if (start) begin
            entry <= '0;
            tab   <= TAB_R;
            done  <= 1'b0;
        end
    end

    // R6: channel pointer only ever cycles through the three tables
    p_tab_legal_r6: assert property (@(posedge clk) disable iff (rst)
        tab != TAB_NONE);

    // R7: once 768 bytes are in, the pointer freezes until the next window start
    p_hold_done_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> ($stable(entry) && $stable(tab)));
endmodule

// File: rtl/clut_triple.sv
module clut_triple
    import clut_pkg::*;
#(
    parameter int LINE_W       = 10,
    parameter int HPOS_W       = 11,
    parameter int FIRST_ACTIVE = 22,
    parameter int HALF_POS     = 429
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              idx_mode,
    input  logic              pix_valid,
    input  logic [7:0]        pix_r,
    input  logic [7:0]        pix_g,
    input  logic [7:0]        pix_b,
    input  logic [LINE_W-1:0] line_cnt,
    input  logic [HPOS_W-1:0] hpos,
    input  logic              inband_en,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [7:0]        reg_addr,
    input  logic [7:0]        reg_data,
    output logic [7:0]        lut_r,
    output logic [7:0]        lut_g,
    output logic [7:0]        lut_b
);
    localparam logic [LINE_W-1:0] PRE2 = LINE_W'(FIRST_ACTIVE - 2);
    localparam logic [LINE_W-1:0] PRE1 = LINE_W'(FIRST_ACTIVE - 1);
    localparam logic [HPOS_W-1:0] HALF = HPOS_W'(HALF_POS);

    tab_e  ib_tab;
    wr_t   ib_wr;
    byte_t pix_in  [NTAB];
    byte_t rd_data [NTAB];
    wr_t   bank_wr [NTAB];
    logic [NTAB-1:0] ib_hit;

    assign pix_in[0] = pix_r;
    assign pix_in[1] = pix_g;
    assign pix_in[2] = pix_b;

    clut_window #(
        .LINE_W(LINE_W), .HPOS_W(HPOS_W),
        .FIRST_ACTIVE(FIRST_ACTIVE), .HALF_POS(HALF_POS)
    ) u_window (
        .clk(clk), .rst(rst), .enable(inband_en),
        .line_cnt(line_cnt), .hpos(hpos), .valid(pix_valid),
        .byte_in(pix_r), .wr_tab(ib_tab), .wr(ib_wr)
    );

    for (genvar t = 0; t < NTAB; t++) begin : g_tab
        addr_t rd_addr;
        assign ib_hit[t] = ib_wr.en && (ib_tab == tab_e'(2'(t)));
        always_comb begin
            if (ib_hit[t]) begin
                bank_wr[t] = ib_wr;
            end else begin
                bank_wr[t].en   = reg_we && (reg_sel == 2'(t));
                bank_wr[t].addr = reg_addr;
                bank_wr[t].data = reg_data;
            end
        end
        assign rd_addr = idx_mode ? pix_r : pix_in[t];
        clut_bank u_bank (
            .clk(clk), .rst(rst), .wr(bank_wr[t]),
            .rd_addr(rd_addr), .rd_data(rd_data[t])
        );
    end

    assign lut_r = rd_data[0];
    assign lut_g = rd_data[1];
    assign lut_b = rd_data[2];

    // R1: reset clears every output on the following edge
    p_rst_clear_r1: assert property (@(posedge clk)
        rst |=> (lut_r == '0 && lut_g == '0 && lut_b == '0));

    // R5: in-band writes only inside the load window, only with enable and valid
    p_window_r5: assert property (@(posedge clk) disable iff (rst)
        ib_wr.en |-> (inband_en && pix_valid &&
                      ((line_cnt == PRE2) || ((line_cnt == PRE1) && (hpos < HALF)))));

    // R8: an in-band byte targets at most one table per cycle
    p_one_table_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ib_hit));
endmodule

// File: tb/clut_triple_tb.sv
module clut_triple_tb;
    localparam int LINE_W = 10, HPOS_W = 11, FIRST_ACTIVE = 22, HALF_POS = 429;
    localparam int LINE_LEN = 858;

    logic clk = 0, rst = 1, idx_mode = 0, pix_valid = 0, inband_en = 0, reg_we = 0;
    logic [7:0] pix_r = 0, pix_g = 0, pix_b = 0, reg_addr = 0, reg_data = 0;
    logic [1:0] reg_sel = 0;
    logic [LINE_W-1:0] line_cnt = 0;
    logic [HPOS_W-1:0] hpos = 0;
    logic [7:0] lut_r, lut_g, lut_b;

    logic [7:0] mdl [3][256];
    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    clut_triple #(.LINE_W(LINE_W), .HPOS_W(HPOS_W),
                  .FIRST_ACTIVE(FIRST_ACTIVE), .HALF_POS(HALF_POS)) u_dut (
        .clk(clk), .rst(rst), .idx_mode(idx_mode), .pix_valid(pix_valid),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .line_cnt(line_cnt), .hpos(hpos), .inband_en(inband_en),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_addr(reg_addr), .reg_data(reg_data),
        .lut_r(lut_r), .lut_g(lut_g), .lut_b(lut_b));

    task automatic tick; @(negedge clk); endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic t_reset;   // R1
        rst = 1; tick; tick;
        chk("R1 r", lut_r, 8'h00); chk("R1 g", lut_g, 8'h00); chk("R1 b", lut_b, 8'h00);
        rst = 0; tick;
    endtask

    task automatic t_reg_fill;   // R4
        for (int t = 0; t < 3; t++)
            for (int a = 0; a < 256; a++) begin
                reg_we = 1; reg_sel = 2'(t); reg_addr = 8'(a);
                reg_data = 8'(a * 5 + t * 77 + 3);
                mdl[t][a] = reg_data;
                tick;
            end
        reg_we = 0; tick;
    endtask

    task automatic t_sweep(input string tag);   // R2
        idx_mode = 0;
        for (int a = 0; a < 256; a++) begin
            pix_r = 8'(a); pix_g = 8'(255 - a); pix_b = 8'(a) ^ 8'h5A;
            tick;
            chk({tag, " r"}, lut_r, mdl[0][a]);
            chk({tag, " g"}, lut_g, mdl[1][255 - a]);
            chk({tag, " b"}, lut_b, mdl[2][8'(a) ^ 8'h5A]);
        end
    endtask

    task automatic t_index;   // R3
        idx_mode = 1;
        for (int a = 0; a < 256; a++) begin
            pix_r = 8'(a); pix_g = 8'(a * 3 + 1); pix_b = 8'(a * 11);
            tick;
            chk("R3 r", lut_r, mdl[0][a]);
            chk("R3 g", lut_g, mdl[1][a]);
            chk("R3 b", lut_b, mdl[2][a]);
        end
        idx_mode = 0;
    endtask

    task automatic t_sel_none;   // R4: sel 3 writes nothing
        reg_we = 1; reg_sel = 2'd3; reg_addr = 8'd7; reg_data = ~mdl[0][7];
        tick; reg_we = 0;
        pix_r = 8'd7; pix_g = 8'd7; pix_b = 8'd7; tick;
        chk("R4 sel3 r", lut_r, mdl[0][7]);
        chk("R4 sel3 g", lut_g, mdl[1][7]);
        chk("R4 sel3 b", lut_b, mdl[2][7]);
    endtask

    task automatic t_read_first;   // R9
        logic [7:0] old_v;
        old_v = mdl[0][9];
        idx_mode = 0; pix_r = 8'd9;
        reg_we = 1; reg_sel = 2'd0; reg_addr = 8'd9; reg_data = ~old_v;
        tick;
        reg_we = 0;
        chk("R9 old", lut_r, old_v);
        mdl[0][9] = ~old_v;
        tick;
        chk("R9 new", lut_r, ~old_v);
    endtask

    // in-band load over lines FIRST_ACTIVE-2 and FIRST_ACTIVE-1
    task automatic t_load(input logic en, input int seed, input int v0, input logic collide);
        int k, sent;
        k = 0; sent = 0;
        inband_en = en;
        for (int ln = FIRST_ACTIVE - 2; ln <= FIRST_ACTIVE - 1; ln++)
            for (int h = 0; h < LINE_LEN; h++) begin
                logic v, inwin;
                v = (ln == FIRST_ACTIVE - 2) ? (h >= v0) : 1'b1;
                inwin = (ln == FIRST_ACTIVE - 2) || (h < HALF_POS);
                line_cnt = LINE_W'(ln); hpos = HPOS_W'(h);
                pix_valid = v;
                pix_r = 8'((seed + sent * 13) ^ (sent >> 3));
                reg_we = 0;
                if (collide && en && v && inwin && k == 10) begin
                    reg_we = 1; reg_sel = 2'd1; reg_addr = 8'd250; reg_data = 8'h55;
                end
                if (collide && en && v && inwin && k == 11) begin
                    reg_we = 1; reg_sel = 2'd1; reg_addr = 8'd251; reg_data = 8'h66;
                    mdl[1][251] = 8'h66;
                end
                if (en && v && inwin && k < 768) begin
                    mdl[k % 3][k / 3] = pix_r;
                    k++;
                end
                if (v) sent++;
                tick;
            end
        reg_we = 0; pix_valid = 0; inband_en = 0;
        line_cnt = 0; hpos = 0; tick;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick;
        t_reset;
        t_reg_fill;
        t_sweep("R2 R4 fill");
        t_sel_none;
        t_index;
        t_read_first;
        t_sweep("R9 after");
        t_load(1'b1, 17, 0, 1'b0);
        t_sweep("R6 R7 full load");
        t_load(1'b0, 90, 0, 1'b0);
        t_sweep("R10 disabled");
        t_load(1'b1, 41, 700, 1'b1);
        t_sweep("R5 R8 window end and collision");
        t_load(1'b1, 123, 0, 1'b0);
        t_sweep("R7 restart");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule